// File: doc/BRIEF.md
# Interleaved Multi-Bank Word Memory

This block is a word-addressed storage array built from eight banks. Each bank holds a configurable number of storage blocks, and each block has 32 rows of 32-bit words. A linear word address is split so that neighbouring addresses fall in different banks. The bank index changes fastest, then the row inside a block, then the block. Past the highest address the space wraps back to bank 0, row 0, block 0.

A self-running clear engine starts after every reset. It writes zero into every word, one word per cycle, in ascending address order. While it runs, the block raises a busy output and ignores all outside traffic. Once busy drops, the block works as a plain single-port memory. A read returns data one cycle later. A read in the same cycle as a write to the same word returns the stored value from before that write.

Top module: `ilvMem`

## Requirements
- R1: Each address from 0 to 8 × BLOCKS × 32 − 1 holds its own 32-bit word. Writing one address never changes another (default 512 words, 9-bit address).
- R2: Address bits [2:0] select the bank, bits [7:3] select the row inside a block, and the bits above select the block. Each write enables exactly one bank, the one named by bits [2:0].
- R3: While reset is high and for exactly 8 × BLOCKS × 32 cycles after it falls, busy is 1. After that, busy is 0.
- R4: After reset, every word reads as zero. The clear writes one word per cycle in ascending address order, starting at address 0.
- R5: While busy is 1, write requests have no effect on the stored words.
- R6: While busy is 1, read data is zero.
- R7: Read data for an address issued at a clock edge appears after that edge and holds until the next access edge. The latency is one cycle.
- R8: A write and a read of the same address in the same cycle returns the word's value from before the write.
- R9: The highest address and address 0 are separate words. There is no aliasing at the end of the space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; starts the clear |
| addr | input | 9 | Word address (width = log2 of word count) |
| wrEn | input | 1 | Write request for the addressed word |
| wrData | input | 32 | Data to write |
| rdData | output | 32 | Registered read data of the last address |
| busy | output | 1 | High while reset or the clear runs |

## Verification
A clear counter that is off by one shows at the ports in one of two ways. Busy stays high for the wrong number of cycles, or the last word (or word 0) holds stale data when it is read just after busy drops. A bad bank or row decode shows up within one write-read pair over the whole space: two addresses alias, so a full write sweep followed by a full read sweep returns the wrong word. A wrong read-select register corrupts read data within one cycle of the access. Writes that leak through during the clear show up on the first read of that address after busy falls.

// File: rtl/ilvMemPkg.sv
package ilvMemPkg;
  // Strobes from the control sequencer to the datapath
  typedef struct packed {
    logic busy;      // clear in progress
    logic clrWrite;  // write a zero at the clear address this cycle
    logic extEn;     // outside accesses are honoured
  } ctlStrobes_t;
endpackage

// File: rtl/ilvMemBank.sv
module ilvMemBank #(
  parameter int DATA_W = 32,
  parameter int ROWS   = 64,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              rdEn,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdQ
);
  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[row] <= wdata;
  end

  // read register samples the array before the write lands: old data
  always_ff @(posedge clk) begin
    if (rst)       rdQ <= '0;
    else if (rdEn) rdQ <= mem[row];
  end
endmodule

// File: rtl/ilvMemCtrl.sv
module ilvMemCtrl import ilvMemPkg::*; #(
  parameter int ADDR_W = 9,
  parameter int DEPTH  = 512
) (
  input  logic              clk,
  input  logic              rst,
  output ctlStrobes_t       strb,
  output logic [ADDR_W-1:0] clrAddr
);
  typedef enum logic {ST_CLEAR, ST_RUN} state_t;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  state_t stateQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ  <= ST_CLEAR;
      clrAddr <= '0;
    end else if (stateQ == ST_CLEAR) begin
      if (clrAddr == LAST) stateQ <= ST_RUN;
      clrAddr <= clrAddr + 1'b1;
    end
  end

  always_comb begin
    strb.busy     = (stateQ == ST_CLEAR);
    strb.clrWrite = (stateQ == ST_CLEAR);
    strb.extEn    = (stateQ == ST_RUN);
  end
endmodule

// File: rtl/ilvMemPath.sv
module ilvMemPath import ilvMemPkg::*; #(
  parameter int NUM_BANKS = 8,
  parameter int LINES     = 32,
  parameter int BLOCKS    = 2,
  parameter int DATA_W    = 32,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ROWS     = LINES * BLOCKS,
  localparam int ROW_W    = $clog2(ROWS),
  localparam int ADDR_W   = BANK_W + ROW_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctlStrobes_t          strb,
  input  logic [ADDR_W-1:0]    clrAddr,
  input  logic [ADDR_W-1:0]    extAddr,
  input  logic                 extWe,
  input  logic [DATA_W-1:0]    extWdata,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_BANKS-1:0] bankWe
);
  logic [ADDR_W-1:0] selAddr;
  logic              selWe;
  logic [DATA_W-1:0] selData;
  logic [BANK_W-1:0] bankIdx;
  logic [ROW_W-1:0]  rowIdx;
  logic [BANK_W-1:0] bankSelQ;
  logic [DATA_W-1:0] bankRd [NUM_BANKS];

  always_comb begin
    selAddr = strb.busy ? clrAddr : extAddr;
    selWe   = strb.busy ? strb.clrWrite : (extWe & strb.extEn);
    selData = strb.busy ? '0 : extWdata;
  end

  // bank fastest, then line, then block: row index {block,line} is the upper slice
  assign bankIdx = selAddr[BANK_W-1:0];
  assign rowIdx  = selAddr[ADDR_W-1:BANK_W];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    assign bankWe[g] = selWe && (bankIdx == BANK_W'(g));
    ilvMemBank #(.DATA_W(DATA_W), .ROWS(ROWS)) i_bank (
      .clk  (clk),
      .rst  (rst),
      .we   (bankWe[g]),
      .rdEn (strb.extEn),
      .row  (rowIdx),
      .wdata(selData),
      .rdQ  (bankRd[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)             bankSelQ <= '0;
    else if (strb.extEn) bankSelQ <= bankIdx;
  end

  assign rdData = bankRd[bankSelQ];
endmodule

// File: rtl/ilvMem.sv
module ilvMem import ilvMemPkg::*; #(
  parameter int NUM_BANKS = 8,
  parameter int LINES     = 32,
  parameter int BLOCKS    = 2,   // power of two, at least 2
  parameter int DATA_W    = 32,
  localparam int DEPTH    = NUM_BANKS * LINES * BLOCKS,
  localparam int ADDR_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              busy
);
  ctlStrobes_t           strb;
  logic [ADDR_W-1:0]     clrAddr;
  logic [NUM_BANKS-1:0]  bankWe;

  ilvMemCtrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .clrAddr(clrAddr)
  );

  ilvMemPath #(
    .NUM_BANKS(NUM_BANKS), .LINES(LINES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)
  ) i_path (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .clrAddr (clrAddr),
    .extAddr (addr),
    .extWe   (wrEn),
    .extWdata(wrData),
    .rdData  (rdData),
    .bankWe  (bankWe)
  );

  assign busy = strb.busy;
endmodule

// File: rtl/ilvMemChecker.sv
module ilvMemChecker #(
  parameter int NUM_BANKS = 8,
  parameter int DEPTH     = 512,
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 32,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 busy,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    rdData,
  input logic [NUM_BANKS-1:0] bankWe
);
  localparam logic [NUM_BANKS-1:0] ONE_HOT0 = NUM_BANKS'(1);
  logic [ADDR_W:0] busyCnt;

  always_ff @(posedge clk) begin
    if (rst)       busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
  end

  assert_busy_len_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> busyCnt == (ADDR_W+1)'(DEPTH));

  assert_zero_read_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> rdData == '0);

  assert_single_bank_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bankWe));

  assert_bank_decode_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && wrEn) |-> bankWe == (ONE_HOT0 << addr[BANK_W-1:0]));

  assert_clear_order_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> bankWe == (ONE_HOT0 << busyCnt[BANK_W-1:0]));

  assert_idle_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (!busy && !wrEn) |-> bankWe == '0);
endmodule

bind ilvMem ilvMemChecker #(
  .NUM_BANKS(NUM_BANKS), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_checker (
  .clk   (clk),
  .rst   (rst),
  .busy  (busy),
  .wrEn  (wrEn),
  .addr  (addr),
  .rdData(rdData),
  .bankWe(bankWe)
);

// File: tb/test_ilvMem.sv
module test_ilvMem;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 512;
  localparam int ADDR_W = 9;
  localparam int NVEC   = 14;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              wrEn = 1'b0;
  logic [31:0]       wrData = '0;
  logic [31:0]       rdData;
  logic              busy;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilvMem i_ilvMem (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .busy(busy)
  );

  // {we, addr, wdata, expected read data}
  localparam logic [73:0] VEC [NVEC] = '{
    {1'b1, 9'd0,   32'hA000_0001, 32'h0},          // R4 cleared word seen as old
    {1'b0, 9'd0,   32'h0,         32'hA000_0001},  // R7
    {1'b1, 9'd1,   32'hB000_0011, 32'h0},          // R2 next bank
    {1'b1, 9'd8,   32'hC000_0008, 32'h0},          // R2 next line same bank
    {1'b0, 9'd1,   32'h0,         32'hB000_0011},  // R1
    {1'b0, 9'd8,   32'h0,         32'hC000_0008},  // R1
    {1'b1, 9'd8,   32'hD000_0008, 32'hC000_0008},  // R8 old data
    {1'b0, 9'd8,   32'h0,         32'hD000_0008},  // R7
    {1'b1, 9'd511, 32'hE000_01FF, 32'h0},          // R9
    {1'b0, 9'd511, 32'h0,         32'hE000_01FF},  // R9
    {1'b0, 9'd0,   32'h0,         32'hA000_0001},  // R9 no aliasing
    {1'b1, 9'd0,   32'hF000_0000, 32'hA000_0001},  // R8
    {1'b0, 9'd0,   32'h0,         32'hF000_0000},  // R7
    {1'b0, 9'd255, 32'h0,         32'h0}           // R1 untouched word
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample at the following negedge
  task automatic access(input logic we, input logic [ADDR_W-1:0] a,
                        input logic [31:0] d, output logic [31:0] q);
    addr = a; wrEn = we; wrData = d;
    @(posedge clk);
    @(negedge clk);
    q = rdData;
    wrEn = 1'b0;
  endtask

  task automatic resetAndCount(output int n);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    n = 0;
    while (busy === 1'b1 && n < DEPTH + 10) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    int n;
    int bad;
    bit zeroSeen;

    // reset state
    repeat (2) @(negedge clk);
    chk("R3 busy in reset", {31'b0, busy}, 32'h1);
    chk("R6 read zero in reset", rdData, 32'h0);

    // clear run: try to write while busy, watch read data
    rst = 1'b0;
    n = 0;
    zeroSeen = 1'b1;
    while (busy === 1'b1 && n < DEPTH + 10) begin
      addr = 9'd5; wrEn = 1'b1; wrData = 32'hDEAD_BEEF;
      if (rdData !== 32'h0) zeroSeen = 1'b0;
      n++;
      @(negedge clk);
    end
    wrEn = 1'b0;
    chk("R3 busy length", n, DEPTH);
    chk("R6 read zero while busy", {31'b0, zeroSeen}, 32'h1);
    access(1'b0, 9'd5, 32'h0, q);
    chk("R5 write during clear ignored", q, 32'h0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      access(VEC[i][73], VEC[i][72:64], VEC[i][63:32], q);
      chk($sformatf("R1/R2/R7/R8/R9 vector %0d", i), q, VEC[i][31:0]);
    end

    // full sweep: every address keeps its own word
    for (int a = 0; a < DEPTH; a++) access(1'b1, ADDR_W'(a), 32'h5A00_0000 ^ (a * 32'h0001_0003), q);
    bad = 0;
    for (int a = 0; a < DEPTH; a++) begin
      access(1'b0, ADDR_W'(a), 32'h0, q);
      if (q !== (32'h5A00_0000 ^ (a * 32'h0001_0003))) bad++;
    end
    chk("R1 R2 sweep mismatches", bad, 0);

    // second reset clears everything written
    resetAndCount(n);
    chk("R3 busy length again", n, DEPTH);
    bad = 0;
    for (int a = 0; a < DEPTH; a++) begin
      access(1'b0, ADDR_W'(a), 32'h0, q);
      if (q !== 32'h0) bad++;
    end
    chk("R4 all words zero after clear", bad, 0);
    access(1'b0, 9'd511, 32'h0, q);
    chk("R4 last word zero", q, 32'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule